// File: doc/BRIEF.md
# Sixteen-Channel Audio Level Meter

This block turns a stream of time-multiplexed signed audio samples into level-meter values. Each sample arrives with a valid strobe and the index of the channel it belongs to. For every channel the block keeps two values.

The first is a smoothed average level. It rises quickly when the signal gets louder and falls slowly when it gets quieter. The second is a peak level. The peak is refreshed only at the end of a fixed measurement window. Once refreshed, it is held for a longer interval before it is allowed to fall.

One frame is one sample per channel, and a frame is complete when the last channel's sample arrives. All window and hold timing is counted in frames, so it follows the sample rate directly. At 48 kHz the defaults give a 0.1 s window of 4800 frames and a 1.5 s hold of 72000 frames.

A display controller reads the values back by placing a channel number on the read-select input. Magnitudes are linear. Scaling for display is done elsewhere.

Top module: `lvl_meter`

## Requirements
- R1: A synchronous active-high reset sets every channel's average, window maximum, displayed peak and hold timer to zero, and sets the frame counter to zero.
- R2: The level of a sample is its absolute value, MAG_W = SAMPLE_W-1 bits wide. The most negative code, -2^(SAMPLE_W-1), saturates to 2^(SAMPLE_W-1)-1.
- R3: On a valid sample whose magnitude m is above the channel's average a, the average becomes a + ((m-a) >> ATTACK_SHIFT), with a default shift of 2.
- R4: On a valid sample with m below a, the average becomes a - ((a-m) >> DECAY_SHIFT), with a default shift of 10. When m equals a, the average is unchanged.
- R5: A sample changes only the addressed channel's average and window maximum. A cycle with the sample-valid input low changes no stored value.
- R6: A frame ends on each valid sample for channel NUM_CH-1. The window closes on the sample that ends frame number WINDOW_FRAMES (default 4800). The displayed peak can change only on that closing sample.
- R7: The window maximum includes the closing sample. At the close, if a channel's window maximum is above its displayed peak, the peak takes that value and the hold timer restarts.
- R8: Otherwise the peak is kept for HOLD_FRAMES/WINDOW_FRAMES windows (default 15) after it was last set. At the close that ends the hold, the peak takes the window maximum, even if that maximum is zero, and the hold timer restarts. Every close starts a new window maximum from zero.
- R9: rdAvg and rdPeak show the stored values of channel rdCh through combinational logic. They reflect a sample from the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleValid | input | 1 | A sample is present this cycle |
| sampleCh | input | CH_W | Channel index of the sample |
| sampleData | input | SAMPLE_W | Signed two's-complement sample |
| rdCh | input | CH_W | Channel selected for readout |
| rdAvg | output | MAG_W | Average level of the selected channel |
| rdPeak | output | MAG_W | Displayed peak of the selected channel |

## Verification
Every result is due at the first clock edge that accepts the sample, because the readout path has no register. The bench drives inputs on the falling edge and walks rdCh across all channels just after the next rising edge. It compares each channel against a frame-by-frame arithmetic model and finishes before the following falling edge.

A peak change is expected only when the model counts the closing sample of a window. Idle cycles are inserted to confirm that nothing moves without a sample.

A small configuration is used: four channels, 8-bit samples, a three-frame window and a three-window hold. With it, every sample code is swept, and both hold expiry and hold restart happen many times.

// File: rtl/lvl_meter_pkg.sv
package lvl_meter_pkg;

  // Strobes sent from the frame control to the per-channel datapath.
  typedef struct packed {
    logic takeSample;   // a sample is accepted this cycle
    logic closeWindow;  // this sample ends the measurement window
  } meterStrobe_t;

endpackage

// File: rtl/lvl_meter_mag.sv
module lvl_meter_mag #(
  parameter int SAMPLE_W = 24,
  localparam int MAG_W = SAMPLE_W - 1
) (
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic        [MAG_W-1:0]    magOut
);

  logic [SAMPLE_W-1:0] negated;

  always_comb begin
    negated = ~sampleIn + 1'b1;
    if (!sampleIn[SAMPLE_W-1]) begin
      magOut = sampleIn[MAG_W-1:0];
    end else if (negated[SAMPLE_W-1]) begin
      // only the most negative code negates to itself: clamp to full scale
      magOut = '1;
    end else begin
      magOut = negated[MAG_W-1:0];
    end
  end

endmodule

// File: rtl/lvl_meter_ctrl.sv
module lvl_meter_ctrl
  import lvl_meter_pkg::*;
#(
  parameter int NUM_CH        = 16,
  parameter int WINDOW_FRAMES = 4800,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int FRAME_W = $clog2(WINDOW_FRAMES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sampleValid,
  input  logic [CH_W-1:0] sampleCh,
  output meterStrobe_t    strobe
);

  logic [FRAME_W-1:0] frameCnt;
  logic               frameEnd;
  logic               windowEnd;

  assign frameEnd  = sampleValid && (sampleCh == CH_W'(NUM_CH - 1));
  assign windowEnd = frameEnd && (frameCnt == FRAME_W'(WINDOW_FRAMES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      frameCnt <= '0;
    end else if (frameEnd) begin
      frameCnt <= windowEnd ? '0 : frameCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.takeSample  = sampleValid;
    strobe.closeWindow = windowEnd;
  end

endmodule

// File: rtl/lvl_meter_datapath.sv
module lvl_meter_datapath
  import lvl_meter_pkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int MAG_W        = 23,
  parameter int ATTACK_SHIFT = 2,
  parameter int DECAY_SHIFT  = 10,
  parameter int HOLD_WINS    = 15,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int HOLD_W = $clog2(HOLD_WINS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  meterStrobe_t     strobe,
  input  logic [CH_W-1:0]  sampleCh,
  input  logic [MAG_W-1:0] mag,
  input  logic [CH_W-1:0]  rdCh,
  output logic [MAG_W-1:0] rdAvg,
  output logic [MAG_W-1:0] rdPeak
);

  logic [MAG_W-1:0] avgArr  [NUM_CH];
  logic [MAG_W-1:0] peakArr [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic              hit;
    logic [MAG_W-1:0]  avgQ;
    logic [MAG_W-1:0]  avgNext;
    logic [MAG_W-1:0]  winQ;
    logic [MAG_W-1:0]  winSeen;
    logic [MAG_W-1:0]  peakQ;
    logic [HOLD_W-1:0] holdQ;
    logic              grow;
    logic              expired;

    assign hit = strobe.takeSample && (sampleCh == CH_W'(c));

    // asymmetric tracker: large step upward, small step downward
    always_comb begin
      if (mag > avgQ) begin
        avgNext = avgQ + ((mag - avgQ) >> ATTACK_SHIFT);
      end else begin
        avgNext = avgQ - ((avgQ - mag) >> DECAY_SHIFT);
      end
    end

    assign winSeen = (hit && (mag > winQ)) ? mag : winQ;
    assign grow    = winSeen > peakQ;
    assign expired = holdQ == HOLD_W'(HOLD_WINS - 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        avgQ  <= '0;
        winQ  <= '0;
        peakQ <= '0;
        holdQ <= '0;
      end else begin
        if (hit) begin
          avgQ <= avgNext;
        end
        if (strobe.closeWindow) begin
          winQ <= '0;
          if (grow || expired) begin
            peakQ <= winSeen;
            holdQ <= '0;
          end else begin
            holdQ <= holdQ + 1'b1;
          end
        end else begin
          winQ <= winSeen;
        end
      end
    end

    assign avgArr[c]  = avgQ;
    assign peakArr[c] = peakQ;
  end

  assign rdAvg  = avgArr[rdCh];
  assign rdPeak = peakArr[rdCh];

endmodule

// File: rtl/lvl_meter.sv
module lvl_meter
  import lvl_meter_pkg::*;
#(
  parameter int NUM_CH        = 16,
  parameter int SAMPLE_W      = 24,
  parameter int WINDOW_FRAMES = 4800,
  parameter int HOLD_FRAMES   = 72000,
  parameter int ATTACK_SHIFT  = 2,
  parameter int DECAY_SHIFT   = 10,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int MAG_W     = SAMPLE_W - 1,
  localparam int HOLD_WINS = HOLD_FRAMES / WINDOW_FRAMES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleValid,
  input  logic [CH_W-1:0]            sampleCh,
  input  logic signed [SAMPLE_W-1:0] sampleData,
  input  logic [CH_W-1:0]            rdCh,
  output logic [MAG_W-1:0]           rdAvg,
  output logic [MAG_W-1:0]           rdPeak
);

  meterStrobe_t     strobe;
  logic [MAG_W-1:0] mag;

  lvl_meter_mag #(.SAMPLE_W(SAMPLE_W)) mag_i (
    .sampleIn (sampleData),
    .magOut   (mag)
  );

  lvl_meter_ctrl #(
    .NUM_CH        (NUM_CH),
    .WINDOW_FRAMES (WINDOW_FRAMES)
  ) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .sampleCh    (sampleCh),
    .strobe      (strobe)
  );

  lvl_meter_datapath #(
    .NUM_CH       (NUM_CH),
    .MAG_W        (MAG_W),
    .ATTACK_SHIFT (ATTACK_SHIFT),
    .DECAY_SHIFT  (DECAY_SHIFT),
    .HOLD_WINS    (HOLD_WINS)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .sampleCh (sampleCh),
    .mag      (mag),
    .rdCh     (rdCh),
    .rdAvg    (rdAvg),
    .rdPeak   (rdPeak)
  );

endmodule

// File: rtl/lvl_meter_chk.sv
module lvl_meter_chk #(
  parameter int NUM_CH   = 16,
  parameter int SAMPLE_W = 24,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int MAG_W = SAMPLE_W - 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sampleValid,
  input logic [CH_W-1:0]            sampleCh,
  input logic signed [SAMPLE_W-1:0] sampleData,
  input logic [CH_W-1:0]            rdCh,
  input logic [MAG_W-1:0]           rdAvg,
  input logic [MAG_W-1:0]           rdPeak
);

  logic [MAG_W-1:0] magC;
  logic             ownSample;

  always_comb begin
    if (sampleData == {1'b1, {(SAMPLE_W-1){1'b0}}}) begin
      magC = '1;
    end else if (sampleData < 0) begin
      magC = MAG_W'(-sampleData);
    end else begin
      magC = MAG_W'(sampleData);
    end
  end

  assign ownSample = sampleValid && (sampleCh == rdCh);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rdAvg == '0 && rdPeak == '0));

  // R5
  idle_avg_chk: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> (!$stable(rdCh) || $stable(rdAvg)));

  // R6
  peak_close_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(sampleValid && sampleCh == CH_W'(NUM_CH - 1)) |=> (!$stable(rdCh) || $stable(rdPeak)));

  // R3
  attack_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (ownSample && magC >= rdAvg) |=>
      (!$stable(rdCh) || (rdAvg >= $past(rdAvg) && rdAvg <= $past(magC))));

  // R4
  decay_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (ownSample && magC <= rdAvg) |=>
      (!$stable(rdCh) || (rdAvg <= $past(rdAvg) && rdAvg >= $past(magC))));

endmodule

bind lvl_meter lvl_meter_chk #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .sampleValid (sampleValid),
  .sampleCh    (sampleCh),
  .sampleData  (sampleData),
  .rdCh        (rdCh),
  .rdAvg       (rdAvg),
  .rdPeak      (rdPeak)
);

// File: tb/lvl_meter_tb_top.sv
module lvl_meter_tb_top;

  localparam int NCH = 4;
  localparam int SW  = 8;
  localparam int WF  = 3;
  localparam int HF  = 9;
  localparam int ATT = 2;
  localparam int DEC = 3;
  localparam int HW  = HF / WF;
  localparam int MW  = SW - 1;
  localparam int FULL = (1 << MW) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sampleValid = 1'b0;
  logic [1:0]        sampleCh = '0;
  logic signed [7:0] sampleData = '0;
  logic [1:0]        rdCh = '0;
  logic [MW-1:0]     rdAvg;
  logic [MW-1:0]     rdPeak;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int mAvg [NCH];
  int mWin [NCH];
  int mPeak [NCH];
  int mHold [NCH];
  bit mGrew [NCH];
  int mFrame = 0;

  always #10 clk = ~clk;

  lvl_meter #(
    .NUM_CH(NCH), .SAMPLE_W(SW), .WINDOW_FRAMES(WF), .HOLD_FRAMES(HF),
    .ATTACK_SHIFT(ATT), .DECAY_SHIFT(DEC)
  ) dut_i (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleCh(sampleCh),
    .sampleData(sampleData), .rdCh(rdCh), .rdAvg(rdAvg), .rdPeak(rdPeak)
  );

  function automatic int refMag(int v);
    if (v == -(1 << MW)) return FULL;
    return (v < 0) ? -v : v;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model of one accepted sample, applied per the requirements
  task automatic modelSample(int ch, int v);
    int m;
    m = refMag(v);
    if (m > mAvg[ch]) mAvg[ch] = mAvg[ch] + ((m - mAvg[ch]) >>> ATT);
    else              mAvg[ch] = mAvg[ch] - ((mAvg[ch] - m) >>> DEC);
    if (m > mWin[ch]) mWin[ch] = m;
    if (ch == NCH - 1) begin
      if (mFrame == WF - 1) begin
        mFrame = 0;
        for (int c = 0; c < NCH; c++) begin
          mGrew[c] = mWin[c] > mPeak[c];
          if (mGrew[c] || mHold[c] == HW - 1) begin
            mPeak[c] = mWin[c];
            mHold[c] = 0;
          end else begin
            mHold[c]++;
          end
          mWin[c] = 0;
        end
      end else begin
        mFrame++;
      end
    end
  endtask

  task automatic checkAll(string tag);
    for (int c = 0; c < NCH; c++) begin
      rdCh = 2'(c);
      #1;
      cmp($sformatf("%s R9 avg ch%0d", tag, c), int'(rdAvg), mAvg[c]);
      cmp($sformatf("%s %s peak ch%0d", tag, mGrew[c] ? "R7" : "R8", c),
          int'(rdPeak), mPeak[c]);
    end
  endtask

  task automatic sendSample(int ch, int v);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleCh    = 2'(ch);
    sampleData  = 8'(v);
    @(posedge clk);
    #1;
    sampleValid = 1'b0;
    modelSample(ch, v);
  endtask

  task automatic idleCycle(int junk);
    @(negedge clk);
    sampleValid = 1'b0;
    sampleCh    = 2'(junk);
    sampleData  = 8'(junk * 37);
    @(posedge clk);
    #1;
    checkAll("R5 idle");
  endtask

  task automatic sendFrame(int d0, int d1, int d2, int d3);
    sendSample(0, d0);
    sendSample(1, d1);
    sendSample(2, d2);
    sendSample(3, d3);
    checkAll("frame");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mAvg[c] = 0; mWin[c] = 0; mPeak[c] = 0; mHold[c] = 0; mGrew[c] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      rdCh = 2'(c);
      #1;
      cmp("R1 reset avg", int'(rdAvg), 0);
      cmp("R1 reset peak", int'(rdPeak), 0);
    end

    // directed: most negative code, attack step, decay step, equal input
    sendSample(0, -128);
    rdCh = 0; #1;
    cmp("R2 R3 saturated attack", int'(rdAvg), 31);
    cmp("R6 peak before close", int'(rdPeak), 0);
    sendSample(1, 0); sendSample(2, 0); sendSample(3, 0);
    sendSample(0, 0);
    rdCh = 0; #1;
    cmp("R4 decay step", int'(rdAvg), 28);
    sendSample(1, 0); sendSample(2, 0); sendSample(3, 0);
    sendSample(0, 28);
    rdCh = 0; #1;
    cmp("R4 equal unchanged", int'(rdAvg), 28);
    sendSample(1, 5); sendSample(2, 0);
    rdCh = 1; #1;
    cmp("R6 peak waits for close", int'(rdPeak), 0);
    sendSample(3, 0);
    rdCh = 0; #1;
    cmp("R2 R7 peak at close", int'(rdPeak), FULL);
    rdCh = 1; #1;
    cmp("R7 peak at close ch1", int'(rdPeak), 5);
    idleCycle(1);
    idleCycle(3);

    // hold expiry: one loud frame then silence
    sendFrame(0, 0, 120, 0);
    for (int f = 0; f < 14; f++) begin
      sendFrame(0, 0, 0, 0);
      if (f % 4 == 1) idleCycle(f);
    end
    rdCh = 2; #1;
    cmp("R8 peak dropped after hold", int'(rdPeak), 0);

    // sweep every sample code across the channels
    for (int v = -128; v < 128; v++) begin
      int lane = v & 3;
      sendFrame(lane == 0 ? v : (v >>> 3), lane == 1 ? v : 0,
                lane == 2 ? v : -(v >>> 2), lane == 3 ? v : 1);
      if ((v & 15) == 7) idleCycle(v);
    end

    // ramp down then silence to walk the peak through many holds
    for (int f = 0; f < 40; f++) begin
      int amp = (f < 20) ? 100 - 5 * f : 0;
      sendFrame(amp, -amp, (f % 5 == 0) ? amp + 20 : 3, -128 + 6 * f);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule